// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the storage and arithmetic half of a small 32-bit load/store processor that takes several clock cycles per instruction. An outside sequencer drives every strobe and select field, one cycle at a time. The datapath carries them out against a program counter, a single word-addressed memory that holds both code and data, a 32-entry register file, and one ALU. The ALU is shared by address arithmetic, PC increment, branch-target computation and register-to-register operations.

Results that a later cycle of the same instruction needs are kept in staging registers: an instruction register, a memory-data register, two operand latches and an ALU result register. Only the instruction register has a load enable. The other four capture every clock, so a value survives for exactly one cycle. The datapath returns two things to the sequencer: the opcode field of the held instruction, which drives dispatch, and the zero flag of the live ALU result, which drives conditional PC writes. A word-wide fill port lets the surrounding logic place code and data into the memory before and between runs.

Top module: `mcd_datapath`

## Requirements
- R1: Reset clears the PC, all staging registers and every register-file entry to zero, so the first fetch after reset reads memory word 0.
- R2: The memory address is the PC when `addr_sel`=0 and the ALU result register when `addr_sel`=1. Word index = address bits [7:2] for 64 words.
- R3: Operand A is the PC when `opa_sel`=0 and latch A when 1. Operand B is latch B for `opb_sel`=00, the constant 4 for 01, the sign-extended IR[15:0] for 10, and that value shifted left by two for 11.
- R4: `pc_sel` 00 loads the live ALU result, 01 the ALU result register, and 10 the jump target {PC[31:28], IR[25:0], 00}. The PC loads when `pc_wr`=1, or when `pc_wr_cond`=1 and the zero flag is 1. Otherwise it holds.
- R5: The register write address is IR[15:11] when `dst_sel`=1 and IR[20:16] when 0. The write data is the memory-data register when `wb_sel`=1 and the ALU result register when 0. Operand latches read the registers named by IR[25:21] and IR[20:16].
- R6: `alu_op`=00 adds and `alu_op`=01 subtracts, whatever the function field holds.
- R7: With `alu_op`=10, function field 0x20 adds, 0x22 subtracts, 0x24 ANDs, 0x25 ORs, 0x26 XORs, 0x27 NORs, and 0x2A gives 1 when A < B as signed numbers, else 0.
- R8: Register 0 always reads zero, and writes to it are dropped.
- R9: Any other function code under `alu_op`=10 performs an add.
- R10: The instruction register changes only on a clock edge with `ir_wr`=1, taking the memory word then addressed.
- R11: `zero` is 1 exactly when the live ALU result is zero.
- R12: With `mem_wr`=1 the word in latch B is written to the memory word addressed per R2. A fill write (`fill_en`=1) to word `fill_idx` takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_wr | input | 1 | Unconditional PC load |
| pc_wr_cond | input | 1 | PC load gated by zero flag |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU result register |
| mem_rd | input | 1 | Memory read enable (read data is zero when low) |
| mem_wr | input | 1 | Memory write of latch B |
| ir_wr | input | 1 | Instruction register load |
| wb_sel | input | 1 | Register write data: 0 ALU result register, 1 memory-data register |
| pc_sel | input | 2 | Next-PC source select |
| alu_op | input | 2 | ALU operation class |
| opb_sel | input | 2 | ALU operand B select |
| opa_sel | input | 1 | ALU operand A select |
| rf_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Register write address: 0 IR[20:16], 1 IR[15:11] |
| fill_en | input | 1 | Memory fill write strobe |
| fill_idx | input | 6 | Memory fill word index |
| fill_data | input | 32 | Memory fill data |
| opcode | output | 6 | IR[31:26] |
| zero | output | 1 | Live ALU result equals zero |

## Verification
The ALU is driven through full load, operate, compare instruction sequences. The operand pairs are chosen so that AND, OR, XOR and NOR each produce a different word from the same inputs. Set-less-than is tried with a negative left operand and again with a negative right operand, which separates a signed compare from an unsigned one. Two unused function codes show whether the add fallback is present. Branch-on-equal is run once with equal operands and once with unequal ones, and a jump is also run. Distinct marker words are placed at the taken and fall-through addresses, so the fetched opcode shows which path the PC took. A stored word is read back through the data-address path, the instruction register is held while the fetch address changes, and register 0 is written and then compared against a known zero.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   typedef enum logic [3:0] {
      FN_AND = 4'b0000,
      FN_OR  = 4'b0001,
      FN_XOR = 4'b0010,
      FN_NOR = 4'b0011,
      FN_ADD = 4'b0110,
      FN_SUB = 4'b1110,
      FN_SLT = 4'b1111
   } alu_fn_e;

   localparam logic [1:0] OPCLS_ADD  = 2'b00;
   localparam logic [1:0] OPCLS_SUB  = 2'b01;
   localparam logic [1:0] OPCLS_FUNC = 2'b10;

   localparam logic [1:0] OPB_LATCH = 2'b00;
   localparam logic [1:0] OPB_FOUR  = 2'b01;
   localparam logic [1:0] OPB_IMM   = 2'b10;
   localparam logic [1:0] OPB_IMMSH = 2'b11;

   localparam logic [1:0] NPC_LIVE   = 2'b00;
   localparam logic [1:0] NPC_STAGED = 2'b01;
   localparam logic [1:0] NPC_JUMP   = 2'b10;

endpackage

// File: rtl/mcd_alu_ctrl.sv
module mcd_alu_ctrl
   import mcd_pkg::*;
(
   input  logic [1:0] op_class,
   input  logic [5:0] funct,
   output alu_fn_e    fn
);

   always_comb begin
      fn = FN_ADD;
      case (op_class)
         OPCLS_ADD: fn = FN_ADD;
         OPCLS_SUB: fn = FN_SUB;
         OPCLS_FUNC: begin
            case (funct)
               6'h20:   fn = FN_ADD;
               6'h22:   fn = FN_SUB;
               6'h24:   fn = FN_AND;
               6'h25:   fn = FN_OR;
               6'h26:   fn = FN_XOR;
               6'h27:   fn = FN_NOR;
               6'h2A:   fn = FN_SLT;
               default: fn = FN_ADD;
            endcase
         end
         default: fn = FN_ADD;
      endcase
   end

endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
   import mcd_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   input  alu_fn_e      fn,
   output logic [W-1:0] res,
   output logic         is_zero
);

   logic lt_signed;
   assign lt_signed = $signed(lhs) < $signed(rhs);

   always_comb begin
      case (fn)
         FN_AND:  res = lhs & rhs;
         FN_OR:   res = lhs | rhs;
         FN_XOR:  res = lhs ^ rhs;
         FN_NOR:  res = ~(lhs | rhs);
         FN_SUB:  res = lhs - rhs;
         FN_SLT:  res = {{(W-1){1'b0}}, lt_signed};
         default: res = lhs + rhs;
      endcase
   end

   assign is_zero = (res == '0);

endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
   parameter int W     = 32,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_a_idx,
   input  logic [AW-1:0] rd_b_idx,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   output logic [W-1:0]  rd_a,
   output logic [W-1:0]  rd_b
);

   logic [DEPTH-1:0][W-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      if (g == 0) begin : g_hardwired
         assign flat[g] = '0;
      end else begin : g_stored
         localparam logic [AW-1:0] SLOT = AW'(g);
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_idx == SLOT)
               q <= wr_data;
         end
         assign flat[g] = q;
      end
   end

   assign rd_a = flat[rd_a_idx];
   assign rd_b = flat[rd_b_idx];

endmodule

// File: rtl/mcd_mem.sv
module mcd_mem #(
   parameter int W     = 32,
   parameter int WORDS = 64,
   localparam int IW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic [W-1:0]  byte_addr,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          fill_en,
   input  logic [IW-1:0] fill_idx,
   input  logic [W-1:0]  fill_data,
   output logic [W-1:0]  rd_data
);

   logic [W-1:0]  store [WORDS];
   logic [IW-1:0] word_idx;
   logic          unused_addr_bits;

   assign word_idx         = byte_addr[IW+1:2];
   assign unused_addr_bits = ^{byte_addr[W-1:IW+2], byte_addr[1:0]};

   always_ff @(posedge clk) begin
      if (fill_en)
         store[fill_idx] <= fill_data;
      else if (wr_en)
         store[word_idx] <= wr_data;
   end

   assign rd_data = rd_en ? store[word_idx] : '0;

endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
   import mcd_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int REG_COUNT = 32,
   parameter int MEM_WORDS = 64,
   localparam int RIDX_W   = $clog2(REG_COUNT),
   localparam int MIDX_W   = $clog2(MEM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc_wr,
   input  logic              pc_wr_cond,
   input  logic              addr_sel,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic              ir_wr,
   input  logic              wb_sel,
   input  logic [1:0]        pc_sel,
   input  logic [1:0]        alu_op,
   input  logic [1:0]        opb_sel,
   input  logic              opa_sel,
   input  logic              rf_wr,
   input  logic              dst_sel,
   input  logic              fill_en,
   input  logic [MIDX_W-1:0] fill_idx,
   input  logic [WORD_W-1:0] fill_data,
   output logic [5:0]        opcode,
   output logic              zero
);

   if (WORD_W != 32) begin : g_bad_width
      $error("mcd_datapath: field slicing assumes a 32-bit word");
   end
   if (REG_COUNT != 32) begin : g_bad_regs
      $error("mcd_datapath: 5-bit register fields need exactly 32 registers");
   end
   if ((1 << MIDX_W) != MEM_WORDS || MIDX_W + 2 > WORD_W) begin : g_bad_mem
      $error("mcd_datapath: memory depth must be a power of two within the address range");
   end

   // staging and architectural registers
   logic [WORD_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;

   logic [WORD_W-1:0] mem_addr, mem_rdata;
   logic [WORD_W-1:0] imm_ext, imm_shl, jump_tgt;
   logic [WORD_W-1:0] opa, opb, alu_res, pc_next;
   logic [WORD_W-1:0] rf_a, rf_b, rf_wdata;
   logic [RIDX_W-1:0] rf_waddr;
   logic              pc_load;
   alu_fn_e           alu_fn;

   assign imm_ext  = {{(WORD_W-16){ir_q[15]}}, ir_q[15:0]};
   assign imm_shl  = {imm_ext[WORD_W-3:0], 2'b00};
   assign jump_tgt = {pc_q[WORD_W-1:WORD_W-4], ir_q[25:0], 2'b00};

   assign mem_addr = addr_sel ? alu_out_q : pc_q;

   mcd_mem #(.W(WORD_W), .WORDS(MEM_WORDS)) u_mem (
      .clk       (clk),
      .byte_addr (mem_addr),
      .rd_en     (mem_rd),
      .wr_en     (mem_wr),
      .wr_data   (b_q),
      .fill_en   (fill_en),
      .fill_idx  (fill_idx),
      .fill_data (fill_data),
      .rd_data   (mem_rdata)
   );

   assign rf_waddr = dst_sel ? ir_q[15:11] : ir_q[20:16];
   assign rf_wdata = wb_sel ? mdr_q : alu_out_q;

   mcd_regfile #(.W(WORD_W), .DEPTH(REG_COUNT)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (ir_q[25:21]),
      .rd_b_idx (ir_q[20:16]),
      .wr_en    (rf_wr),
      .wr_idx   (rf_waddr),
      .wr_data  (rf_wdata),
      .rd_a     (rf_a),
      .rd_b     (rf_b)
   );

   assign opa = opa_sel ? a_q : pc_q;

   always_comb begin
      case (opb_sel)
         OPB_LATCH: opb = b_q;
         OPB_FOUR:  opb = WORD_W'(4);
         OPB_IMM:   opb = imm_ext;
         default:   opb = imm_shl;
      endcase
   end

   mcd_alu_ctrl u_alu_ctrl (
      .op_class (alu_op),
      .funct    (ir_q[5:0]),
      .fn       (alu_fn)
   );

   mcd_alu #(.W(WORD_W)) u_alu (
      .lhs     (opa),
      .rhs     (opb),
      .fn      (alu_fn),
      .res     (alu_res),
      .is_zero (zero)
   );

   always_comb begin
      case (pc_sel)
         NPC_STAGED: pc_next = alu_out_q;
         NPC_JUMP:   pc_next = jump_tgt;
         default:    pc_next = alu_res;
      endcase
   end

   assign pc_load = pc_wr | (pc_wr_cond & zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q      <= '0;
         ir_q      <= '0;
         mdr_q     <= '0;
         a_q       <= '0;
         b_q       <= '0;
         alu_out_q <= '0;
      end else begin
         if (pc_load) pc_q <= pc_next;
         if (ir_wr)   ir_q <= mem_rdata;
         mdr_q     <= mem_rdata;
         a_q       <= rf_a;
         b_q       <= rf_b;
         alu_out_q <= alu_res;
      end
   end

   assign opcode = ir_q[31:26];

endmodule

// File: rtl/mcd_datapath_chk.sv
module mcd_datapath_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pc_wr,
   input logic        pc_wr_cond,
   input logic        zero,
   input logic        ir_wr,
   input logic [1:0]  pc_sel,
   input logic        opa_sel,
   input logic [1:0]  opb_sel,
   input logic [1:0]  alu_op,
   input logic [31:0] pc_q,
   input logic [31:0] ir_q,
   input logic [31:0] a_q,
   input logic [31:0] b_q,
   input logic [31:0] alu_out_q
);

   assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q));

   assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr && pc_sel == 2'b00 && !opa_sel && opb_sel == 2'b01 && alu_op == 2'b00)
      |=> (pc_q == $past(pc_q) + 32'd4));

   assert_jump_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr && pc_sel == 2'b10)
      |=> (pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00}));

   assert_ir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_wr |=> $stable(ir_q));

   assert_r0_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_q[25:21] == 5'd0) |=> (a_q == 32'd0));

   assert_latch_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (opa_sel && opb_sel == 2'b00 && alu_op == 2'b00)
      |=> (alu_out_q == $past(a_q) + $past(b_q)));

endmodule

bind mcd_datapath mcd_datapath_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pc_wr     (pc_wr),
   .pc_wr_cond(pc_wr_cond),
   .zero      (zero),
   .ir_wr     (ir_wr),
   .pc_sel    (pc_sel),
   .opa_sel   (opa_sel),
   .opb_sel   (opb_sel),
   .alu_op    (alu_op),
   .pc_q      (pc_q),
   .ir_q      (ir_q),
   .a_q       (a_q),
   .b_q       (b_q),
   .alu_out_q (alu_out_q)
);

// File: tb/mcd_datapath_test.sv
module mcd_datapath_test;

   typedef struct packed {
      logic       pcw, pcwc, iord, mrd, mwr, irw, m2r;
      logic [1:0] pcs, aop, bsel;
      logic       asel, rfw, rdst;
   } ctl_t;

   typedef struct packed {
      logic [5:0]  f;
      logic [31:0] a, b, y;
      logic        fallback;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{6'h20, 32'h1234_5678, 32'h1111_1111, 32'h2345_6789, 1'b0},
      '{6'h22, 32'h0000_0010, 32'h0000_0020, 32'hFFFF_FFF0, 1'b0},
      '{6'h24, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'h00F0_F000, 1'b0},
      '{6'h25, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'hFFF0_FFF0, 1'b0},
      '{6'h26, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'hFF00_0FF0, 1'b0},
      '{6'h27, 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'h000F_000F, 1'b0},
      '{6'h2A, 32'hFFFF_FFFB, 32'h0000_0003, 32'h0000_0001, 1'b0},
      '{6'h2A, 32'h0000_0003, 32'hFFFF_FFFB, 32'h0000_0000, 1'b0},
      '{6'h00, 32'h0000_0007, 32'h0000_0009, 32'h0000_0010, 1'b1},
      '{6'h3F, 32'h0000_0100, 32'h0000_0001, 32'h0000_0101, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   ctl_t        ctl;
   logic        fill_en;
   logic [5:0]  fill_idx;
   logic [31:0] fill_data;
   logic [5:0]  opcode;
   logic        zero;

   int          n_chk  = 0;
   int          n_fail = 0;
   logic [31:0] exp_pc;
   logic        last_zero;
   logic        ex_zero;

   always #2 clk = ~clk;

   mcd_datapath uut (
      .clk(clk), .rst_n(rst_n),
      .pc_wr(ctl.pcw), .pc_wr_cond(ctl.pcwc), .addr_sel(ctl.iord),
      .mem_rd(ctl.mrd), .mem_wr(ctl.mwr), .ir_wr(ctl.irw), .wb_sel(ctl.m2r),
      .pc_sel(ctl.pcs), .alu_op(ctl.aop), .opb_sel(ctl.bsel), .opa_sel(ctl.asel),
      .rf_wr(ctl.rfw), .dst_sel(ctl.rdst),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_data(fill_data),
      .opcode(opcode), .zero(zero)
   );

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic ctl_t c_idle();
      return '0;
   endfunction
   function automatic ctl_t c_fetch();
      ctl_t c = '0; c.mrd = 1; c.irw = 1; c.bsel = 2'b01; c.pcw = 1; return c;
   endfunction
   function automatic ctl_t c_decode();
      ctl_t c = '0; c.bsel = 2'b11; return c;
   endfunction
   function automatic ctl_t c_rexec();
      ctl_t c = '0; c.asel = 1; c.aop = 2'b10; return c;
   endfunction
   function automatic ctl_t c_rwb();
      ctl_t c = '0; c.rfw = 1; c.rdst = 1; return c;
   endfunction
   function automatic ctl_t c_addr();
      ctl_t c = '0; c.asel = 1; c.bsel = 2'b10; return c;
   endfunction
   function automatic ctl_t c_mread();
      ctl_t c = c_addr(); c.iord = 1; c.mrd = 1; return c;
   endfunction
   function automatic ctl_t c_lwb();
      ctl_t c = '0; c.rfw = 1; c.m2r = 1; return c;
   endfunction
   function automatic ctl_t c_swr();
      ctl_t c = c_addr(); c.iord = 1; c.mwr = 1; return c;
   endfunction
   function automatic ctl_t c_beq();
      ctl_t c = '0; c.asel = 1; c.aop = 2'b01; c.pcs = 2'b01; c.pcwc = 1; return c;
   endfunction
   function automatic ctl_t c_jmp();
      ctl_t c = '0; c.pcs = 2'b10; c.pcw = 1; return c;
   endfunction

   function automatic logic [31:0] r_word(input logic [4:0] rs, rt, rd, input logic [5:0] f);
      return {6'h00, rs, rt, rd, 5'd0, f};
   endfunction
   function automatic logic [31:0] i_word(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   // one controller cycle: drive at negedge, sample zero mid-cycle, advance one edge
   task automatic apply(input ctl_t c);
      ctl = c;
      #1 last_zero = zero;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic fill(input int idx, input logic [31:0] val);
      ctl       = c_idle();
      fill_en   = 1'b1;
      fill_idx  = 6'(idx);
      fill_data = val;
      @(posedge clk);
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic load_instr(input logic [31:0] w);
      if (exp_pc[7:2] >= 6'd40) begin
         fill(int'(exp_pc[7:2]), {6'h02, 26'd0});
         apply(c_fetch());
         apply(c_decode());
         apply(c_jmp());
         exp_pc = 32'd0;
      end
      fill(int'(exp_pc[7:2]), w);
      apply(c_fetch());
      exp_pc = exp_pc + 32'd4;
      apply(c_decode());
   endtask

   task automatic run_r(input logic [4:0] rs, rt, rd, input logic [5:0] f);
      load_instr(r_word(rs, rt, rd, f));
      apply(c_rexec());
      ex_zero = last_zero;
      apply(c_rwb());
   endtask

   task automatic run_lw(input logic [4:0] rt, input int widx);
      load_instr(i_word(6'h23, 5'd0, rt, 16'(widx * 4)));
      apply(c_addr());
      apply(c_mread());
      apply(c_lwb());
   endtask

   task automatic run_sw(input logic [4:0] rt, input int widx);
      load_instr(i_word(6'h2B, 5'd0, rt, 16'(widx * 4)));
      apply(c_addr());
      apply(c_swr());
   endtask

   // marker words at the expected and the alternative address; a raw fetch shows which one the PC names
   task automatic verify_pc(input string req, input int exp_idx, input int other_idx);
      fill(other_idx, {6'h11, 26'd0});
      fill(exp_idx, {6'h3A, 26'd0});
      apply(c_fetch());
      check_eq(req, 32'(opcode), 32'h3A);
      exp_pc = 32'((exp_idx + 1) * 4);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int tgt;
      int fall;
      rst_n   = 1'b0;
      ctl     = c_idle();
      fill_en = 1'b0;
      fill_idx = '0;
      fill_data = '0;
      exp_pc  = 32'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: cleared state; idle controls add PC and latch B, both zero
      check_eq("R1 opcode after reset", 32'(opcode), 32'h0);
      #1 check_eq("R1 zero after reset", 32'(zero), 32'h1);
      @(negedge clk);
      verify_pc("R1 first fetch from word 0", 0, 1);

      // table walk: load operands, operate, compare with the expected word
      for (int i = 0; i < NV; i++) begin
         fill(48, VECS[i].a);
         fill(49, VECS[i].b);
         fill(50, VECS[i].y);
         run_lw(5'd1, 48);
         run_lw(5'd2, 49);
         run_lw(5'd3, 50);
         run_r(5'd1, 5'd2, 5'd4, VECS[i].f);
         run_r(5'd4, 5'd3, 5'd0, 6'h22);
         if (VECS[i].fallback)
            check_eq("R9 unknown function adds", 32'(ex_zero), 32'h1);
         else
            check_eq("R7 R5 function result", 32'(ex_zero), 32'h1);
      end

      // R8: attempt to write register 0, then compare it against a loaded zero
      run_r(5'd1, 5'd2, 5'd0, 6'h20);
      fill(51, 32'h0);
      run_lw(5'd6, 51);
      run_r(5'd0, 5'd6, 5'd0, 6'h22);
      check_eq("R8 register 0 stays zero", 32'(ex_zero), 32'h1);

      // R11: nonzero difference (0x100 - 1)
      run_r(5'd1, 5'd2, 5'd0, 6'h22);
      check_eq("R11 zero low on nonzero result", 32'(ex_zero), 32'h0);

      // R10: memory at the PC changes, IR must not follow without ir_wr
      fill(int'(exp_pc[7:2]), {6'h3F, 26'd0});
      check_eq("R10 IR holds after fill", 32'(opcode), 32'h0);
      begin
         ctl_t c = c_idle();
         c.mrd = 1;
         apply(c);
      end
      check_eq("R10 IR holds during read", 32'(opcode), 32'h0);

      // R12 and R2: store, then read back through the data address path
      fill(48, 32'hAC00_1234);
      fill(53, 32'h0);
      run_lw(5'd1, 48);
      run_sw(5'd1, 53);
      begin
         ctl_t c = c_addr();
         c.iord = 1; c.mrd = 1; c.irw = 1;
         apply(c);
      end
      check_eq("R12 R2 stored word read back", 32'(opcode), 32'h2B);

      // R4 R3 R6: branch taken on equal operands
      fill(48, 32'h55);
      run_lw(5'd1, 48);
      run_lw(5'd2, 48);
      load_instr(i_word(6'h04, 5'd1, 5'd2, 16'd3));
      apply(c_beq());
      check_eq("R6 subtract equal gives zero", 32'(last_zero), 32'h1);
      fall = int'(exp_pc[7:2]);
      tgt  = fall + 3;
      verify_pc("R4 R3 branch taken target", tgt, fall);

      // branch not taken on unequal operands
      fill(49, 32'h56);
      run_lw(5'd2, 49);
      load_instr(i_word(6'h04, 5'd1, 5'd2, 16'd3));
      apply(c_beq());
      check_eq("R11 unequal compare not zero", 32'(last_zero), 32'h0);
      fall = int'(exp_pc[7:2]);
      verify_pc("R4 branch not taken", fall, fall + 3);

      // jump
      load_instr({6'h02, 26'd7});
      apply(c_jmp());
      verify_pc("R4 jump target", 7, int'(exp_pc[7:2]));

      // R1: reset mid-run clears registers and PC
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check_eq("R1 opcode after second reset", 32'(opcode), 32'h0);
      exp_pc = 32'd0;
      verify_pc("R1 refetch from word 0", 0, 2);
      run_r(5'd1, 5'd0, 5'd0, 6'h22);
      check_eq("R1 register cleared by reset", 32'(ex_zero), 32'h1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule